// File: doc/BRIEF.md
# Pin Pull Resistor Control Bank

This block holds the pull resistor configuration for a bank of I/O pins. Every pin has an internal pull-up and an internal pull-down. Software writes one-hot style masks to dedicated "turn on" and "turn off" locations for each direction. It reads the resulting state back from two status locations. Each status bit is stored active-low: a one means that resistor is off.

The bank keeps the two resistors on a pin from being on together. A request to enable one direction is dropped for each pin whose opposite resistor is active at that moment. The request still applies to the other pins named in the same write.

Pull control is independent of whether the pin is driven by general-purpose logic or by a peripheral. Access is a single-cycle register write, with a read port that is decoded combinationally from the address. The per-pin enable outputs go straight to the pad cells.

Top module: `pull_ctl_bank`

## Requirements
- R1: After reset, every pull-up is on and every pull-down is off. The pull-up status reads 0x00000000 and the pull-down status reads 0xFFFFFFFF.
- R2: A write to address 0 (pull-up on) clears the pull-up status bit of every pin whose data bit is one, provided that pin's pull-down is off.
- R3: A write to address 1 (pull-up off) sets the pull-up status bit of every pin whose data bit is one.
- R4: A write to address 3 (pull-down on) clears the pull-down status bit of every pin whose data bit is one, provided that pin's pull-up is off.
- R5: A write to address 4 (pull-down off) sets the pull-down status bit of every pin whose data bit is one.
- R6: In a pull-down-on write, pins whose pull-up is on, judged by the state before the write, keep their pull-down off. The other selected pins still change.
- R7: In a pull-up-on write, pins whose pull-down is on, judged by the state before the write, keep their pull-up off. The other selected pins still change.
- R8: Zero data bits in a write leave the matching status bits unchanged. No state changes in a cycle without a write strobe.
- R9: Address 2 reads the pull-up status and address 5 reads the pull-down status. In both, a one means the resistor is off.
- R10: Reads of addresses 0, 1, 3, 4, 6 and 7 return zero. Writes to addresses 2, 5, 6 and 7 change nothing.
- R11: Each pull-up enable output is the inverse of its status bit, and the same holds for pull-down. The two enables of a pin are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data, one bit per pin |
| rdata | output | 32 | Read data for the current address |
| pu_en | output | 32 | Per-pin pull-up enable, active high |
| pd_en | output | 32 | Per-pin pull-down enable, active high |

## Verification
The assertions assume one access per cycle and that the write strobe, address and data are stable across the sampling edge. They assume no other input is involved. Because all eight address codes are legal, the assertions need no address constraint. The bench drives every input at the falling edge. Random stimulus draws addresses over the full three-bit range and data over the full 32 bits. Directed cases then build pins where the opposite resistor is on, so that the discard paths are exercised on mixed masks.

// File: rtl/pull_ctl_bank.sv
module pull_ctl_bank #(
  parameter int NPINS = 32,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] rdata,
  output logic [NPINS-1:0] pu_en,
  output logic [NPINS-1:0] pd_en
);
  localparam logic [AW-1:0] A_PU_ON   = AW'(0);
  localparam logic [AW-1:0] A_PU_OFF  = AW'(1);
  localparam logic [AW-1:0] A_PU_STAT = AW'(2);
  localparam logic [AW-1:0] A_PD_ON   = AW'(3);
  localparam logic [AW-1:0] A_PD_OFF  = AW'(4);
  localparam logic [AW-1:0] A_PD_STAT = AW'(5);

  logic [NPINS-1:0] pu_stat, pd_stat;
  logic [NPINS-1:0] pu_nxt, pd_nxt;

  always_comb begin
    pu_nxt = pu_stat;
    pd_nxt = pd_stat;
    if (wr_en) begin
      unique case (addr)
        A_PU_ON:  pu_nxt = pu_stat & ~(wdata & pd_stat);
        A_PU_OFF: pu_nxt = pu_stat | wdata;
        A_PD_ON:  pd_nxt = pd_stat & ~(wdata & pu_stat);
        A_PD_OFF: pd_nxt = pd_stat | wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pu_stat <= '0;
      pd_stat <= '1;
    end else begin
      pu_stat <= pu_nxt;
      pd_stat <= pd_nxt;
    end
  end

  always_comb begin
    unique case (addr)
      A_PU_STAT: rdata = pu_stat;
      A_PD_STAT: rdata = pd_stat;
      default:   rdata = '0;
    endcase
  end

  assign pu_en = ~pu_stat;
  assign pd_en = ~pd_stat;
endmodule

// File: rtl/pull_ctl_bank_chk.sv
module pull_ctl_bank_chk #(
  parameter int NPINS = 32,
  parameter int AW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [AW-1:0]    addr,
  input logic [NPINS-1:0] wdata,
  input logic [NPINS-1:0] pu_en,
  input logic [NPINS-1:0] pd_en
);
  AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (pu_en & pd_en) == '0); // R11

  AST_PU_ON_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(0)) |=> ((pu_en & ($past(wdata) & ~$past(pd_en))) == ($past(wdata) & ~$past(pd_en)))); // R2

  AST_PU_ON_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(0)) |=> ((pu_en & $past(pd_en)) == '0)); // R7

  AST_PD_ON_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(3)) |=> ((pd_en & $past(pu_en)) == '0)); // R6

  AST_PD_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(4)) |=> ((pd_en & $past(wdata)) == '0)); // R5

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(pu_en) && $stable(pd_en))); // R8
endmodule

bind pull_ctl_bank pull_ctl_bank_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .pu_en(pu_en), .pd_en(pd_en)
);

// File: tb/pull_ctl_bank_tb.sv
`timescale 1ns/1ps
module pull_ctl_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, pu_en, pd_en;
  logic [31:0] m_pu = '0, m_pd = '1;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  pull_ctl_bank u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pu_en(pu_en), .pd_en(pd_en));

  function automatic void model(input logic [2:0] a, input logic [31:0] d);
    case (a)
      3'd0: m_pu = m_pu & ~(d & m_pd);
      3'd1: m_pu = m_pu | d;
      3'd3: m_pd = m_pd & ~(d & m_pu);
      3'd4: m_pd = m_pd | d;
      default: ;
    endcase
  endfunction

  function automatic logic [31:0] rd_exp(input logic [2:0] a);
    return (a == 3'd2) ? m_pu : (a == 3'd5) ? m_pd : 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    model(a, d);
  endtask

  task automatic outs(input string tag);
    chk({tag, " pu_en"}, pu_en, ~m_pu);
    chk({tag, " pd_en"}, pd_en, ~m_pd);
    chk("R11 exclusive", pu_en & pd_en, 32'h0);
  endtask

  task automatic rd(input string tag, input logic [2:0] a);
    @(negedge clk);
    addr = a;
    #1 chk(tag, rdata, rd_exp(a));
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    outs("R1");
    rd("R1 pu stat", 3'd2);
    rd("R1 pd stat", 3'd5);

    wr(3'd1, 32'h0000_00FF); outs("R3");
    wr(3'd3, 32'h0000_0F0F); outs("R6 R4");
    rd("R9 pd stat", 3'd5);
    wr(3'd0, 32'h0000_00F0); outs("R7 R2");
    rd("R9 pu stat", 3'd2);
    wr(3'd4, 32'h0000_000C); outs("R5");
    wr(3'd0, 32'h0000_000F); outs("R2 R7");
    wr(3'd1, 32'h0); outs("R8 zero data");
    @(negedge clk); wdata = 32'hFFFF_FFFF; @(negedge clk); outs("R8 no strobe");
    wr(3'd2, 32'hFFFF_FFFF); outs("R10 write stat");
    wr(3'd5, 32'h0); outs("R10 write stat");
    wr(3'd6, 32'hFFFF_FFFF); wr(3'd7, 32'hFFFF_FFFF); outs("R10 unmapped");
    for (int a = 0; a < 8; a++) rd("R10 R9 read map", 3'(a));

    for (int i = 0; i < 400; i++) begin
      logic [2:0] a;
      a = 3'($urandom % 8);
      wr(a, $urandom & $urandom);
      outs("R2 R3 R4 R5 random");
      if (i % 16 == 0) begin
        rd("R9 random", 3'd2);
        rd("R9 random", 3'd5);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule